// File: doc/BRIEF.md
# Enhanced Parallel Port Write Cycle Controller with Handshake Watchdog

This block runs one write cycle of an enhanced parallel port from the host side. A host write strobe starts the cycle. The block puts the byte on the port data lines and pulls either the address strobe or the data strobe low. It then waits for the peripheral to raise its wait line as the acknowledge. The host bus is held stalled for the whole cycle.

A watchdog limits the wait to a fixed time. The default is 10 us, turned into a cycle count from the clock frequency parameter. The cycle ends on the acknowledge or on watchdog expiry, whichever comes first, and a one-clock done pulse marks the end. On expiry a sticky timeout flag is set. This flag is status bit 0, and host software polls it after each cycle to decide whether to continue, retry or give up. Software clears the flag by writing 1 to bit 0.

Top module: `epp_wr_ctrl`

## Requirements
- R1: After reset: host_wait_o=0, done_o=0, timeout_o=0, astb_no=1, dstb_no=1, pd_o=0.
- R2: A high-to-low transition of wr_stb_ni sampled while idle starts a cycle at that clock edge. From then on host_wait_o=1 and pd_o equals wr_data_i. If wr_addr_i=1 then astb_no=0 (address cycle). If wr_addr_i=0 then dstb_no=0 (data cycle).
- R3: nwait_i passes through a two-flop synchronizer before its rising edge is detected. Let the start edge be edge 0. If nwait_i rises before edge k (k>=1), the cycle ends at edge k+2, so host_wait_o stays high for k+2 cycles.
- R4: The watchdog limit is TERM = CLK_HZ*TIMEOUT_NS/1e9 clock cycles. If no acknowledge arrives, the cycle ends after exactly TERM busy cycles and timeout_o becomes 1.
- R5: If the acknowledge and watchdog expiry fall in the same cycle, the acknowledge wins and timeout_o is not set by that cycle.
- R6: At the end of a cycle, astb_no and dstb_no both return to 1 and host_wait_o falls. done_o is 1 for exactly the one cycle that follows.
- R7: timeout_o is sticky. A completed cycle does not clear it, and stat_we_i with stat_wbit0_i=0 does not clear it. Only stat_we_i=1 with stat_wbit0_i=1 clears it.
- R8: If a clear write and a new timeout occur at the same clock edge, timeout_o ends up 1.
- R9: A falling wr_stb_ni while a cycle is busy is ignored. pd_o, the strobes and the cycle length stay unchanged, and no new cycle follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_stb_ni | input | 1 | Host write strobe, active low; a falling edge starts a cycle |
| wr_addr_i | input | 1 | 1 = address cycle, 0 = data cycle |
| wr_data_i | input | 8 | Byte to write |
| stat_we_i | input | 1 | Host write to the status register |
| stat_wbit0_i | input | 1 | Value written to status bit 0 (1 clears the flag) |
| nwait_i | input | 1 | Peripheral wait/acknowledge line, asynchronous |
| astb_no | output | 1 | Port address strobe, active low |
| dstb_no | output | 1 | Port data strobe, active low |
| pd_o | output | 8 | Port data lines |
| host_wait_o | output | 1 | Host bus stall for the whole cycle |
| done_o | output | 1 | One-clock pulse at cycle end |
| timeout_o | output | 1 | Status bit 0: sticky watchdog timeout flag |

## Verification
The hardest case to reach is the boundary between acknowledge and expiry. This is the cycle where the synchronized nWait edge lands on the same clock as the last watchdog count. There, one cycle of delay in the synchronizer decides whether the flag is set. The bench uses a 20-cycle watchdog and sweeps the acknowledge delay one cycle at a time, from immediate to past expiry. It computes the expected length and flag for each delay. A second hard case is a clear write that lands on the expiry edge. The bench times that write to the exact negedge before the final count.

// File: rtl/epp_pkg.sv
package epp_pkg;

  typedef enum logic {
    CYC_DATA = 1'b0,
    CYC_ADDR = 1'b1
  } cyc_kind_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } cyc_state_e;

  // watchdog terminal count in clock cycles, at least 2
  function automatic int unsigned wdog_term(longint unsigned hz, longint unsigned ns);
    longint unsigned t;
    t = (hz * ns) / 64'd1_000_000_000;
    if (t < 64'd2) t = 64'd2;
    return int'(t);
  endfunction

endpackage

// File: rtl/epp_sync.sv
module epp_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/epp_wdog.sv
module epp_wdog #(
  parameter int unsigned TERM = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(TERM + 1);
  localparam logic [CW-1:0] LAST = CW'(TERM - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (start_i)                cnt_q <= '0;
    else if (run_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/epp_cycle_fsm.sv
module epp_cycle_fsm
  import epp_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  cyc_kind_e     kind_i,
  input  logic [DW-1:0] data_i,
  input  logic          ack_i,
  input  logic          expire_i,
  output logic          busy_o,
  output logic          astb_no,
  output logic          dstb_no,
  output logic [DW-1:0] pd_o,
  output logic          done_o,
  output logic          to_evt_o
);
  cyc_state_e    st_q;
  logic          end_c;

  assign busy_o   = (st_q == ST_BUSY);
  assign end_c    = busy_o && (ack_i || expire_i);
  assign to_evt_o = busy_o && expire_i && !ack_i;  // acknowledge wins a tie

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      astb_no <= 1'b1;
      dstb_no <= 1'b1;
      pd_o    <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= end_c;
      if (start_i && !busy_o) begin
        st_q    <= ST_BUSY;
        pd_o    <= data_i;
        astb_no <= !(kind_i == CYC_ADDR);
        dstb_no <= !(kind_i == CYC_DATA);
      end else if (end_c) begin
        st_q    <= ST_IDLE;
        astb_no <= 1'b1;
        dstb_no <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/epp_status.sv
module epp_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;   // new timeout beats clear
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/epp_wr_ctrl.sv
module epp_wr_ctrl
  import epp_pkg::*;
#(
  parameter longint unsigned CLK_HZ     = 100_000_000,
  parameter longint unsigned TIMEOUT_NS = 10_000,
  parameter int unsigned     SYNC_STG   = 2,
  parameter int unsigned     DW         = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_stb_ni,
  input  logic          wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          stat_we_i,
  input  logic          stat_wbit0_i,
  input  logic          nwait_i,
  output logic          astb_no,
  output logic          dstb_no,
  output logic [DW-1:0] pd_o,
  output logic          host_wait_o,
  output logic          done_o,
  output logic          timeout_o
);
  localparam int unsigned TERM = wdog_term(CLK_HZ, TIMEOUT_NS);

  logic stb_q, stb_fall;
  logic nw_s, nw_d, nw_rise;
  logic busy, expire, to_evt;
  cyc_kind_e kind;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q <= 1'b1;
      nw_d  <= 1'b0;
    end else begin
      stb_q <= wr_stb_ni;
      nw_d  <= nw_s;
    end
  end

  assign stb_fall = stb_q && !wr_stb_ni;
  assign nw_rise  = nw_s && !nw_d;
  assign kind     = wr_addr_i ? CYC_ADDR : CYC_DATA;

  epp_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b0)) u_nw_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (nwait_i),
    .q_o   (nw_s)
  );

  epp_wdog #(.TERM(TERM)) u_wdog (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (stb_fall && !busy),
    .run_i   (busy),
    .expire_o(expire)
  );

  epp_cycle_fsm #(.DW(DW)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (stb_fall),
    .kind_i  (kind),
    .data_i  (wr_data_i),
    .ack_i   (nw_rise),
    .expire_i(expire),
    .busy_o  (busy),
    .astb_no (astb_no),
    .dstb_no (dstb_no),
    .pd_o    (pd_o),
    .done_o  (done_o),
    .to_evt_o(to_evt)
  );

  epp_status u_stat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (to_evt),
    .clr_i (stat_we_i && stat_wbit0_i),
    .flag_o(timeout_o)
  );

  assign host_wait_o = busy;
endmodule

// File: rtl/epp_wr_ctrl_chk.sv
module epp_wr_ctrl_chk #(
  parameter int unsigned TERM = 1000,
  parameter int unsigned DW   = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          stat_we_i,
  input logic          stat_wbit0_i,
  input logic          astb_no,
  input logic          dstb_no,
  input logic [DW-1:0] pd_o,
  input logic          host_wait_o,
  input logic          done_o,
  input logic          timeout_o
);
  logic [31:0] run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          run_cnt <= '0;
    else if (host_wait_o) run_cnt <= run_cnt + 1;
    else                  run_cnt <= '0;
  end

  p_one_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!astb_no && !dstb_no));

  p_strobe_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!astb_no || !dstb_no) == host_wait_o);

  p_wdog_limit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_cnt <= TERM);

  p_done_after_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(host_wait_o) |-> done_o);

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_o && !(stat_we_i && stat_wbit0_i)) |=> timeout_o);

  p_pd_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wait_o && $past(host_wait_o)) |-> $stable(pd_o));
endmodule

bind epp_wr_ctrl epp_wr_ctrl_chk #(.TERM(TERM), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .stat_we_i   (stat_we_i),
  .stat_wbit0_i(stat_wbit0_i),
  .astb_no     (astb_no),
  .dstb_no     (dstb_no),
  .pd_o        (pd_o),
  .host_wait_o (host_wait_o),
  .done_o      (done_o),
  .timeout_o   (timeout_o)
);

// File: tb/tb_epp_wr_ctrl.sv
module tb_epp_wr_ctrl;
  localparam int TERM = 20;  // 100 MHz * 200 ns

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_stb_ni = 1'b1;
  logic       wr_addr_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       stat_we_i = 1'b0;
  logic       stat_wbit0_i = 1'b0;
  logic       nwait_i = 1'b0;
  logic       astb_no, dstb_no, host_wait_o, done_o, timeout_o;
  logic [7:0] pd_o;

  int n_run = 0;
  int n_fail = 0;
  bit exp_to = 1'b0;

  always #5 clk_i = ~clk_i;

  epp_wr_ctrl #(.CLK_HZ(100_000_000), .TIMEOUT_NS(200)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_stb_ni(wr_stb_ni), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .stat_we_i(stat_we_i), .stat_wbit0_i(stat_wbit0_i),
    .nwait_i(nwait_i), .astb_no(astb_no), .dstb_no(dstb_no), .pd_o(pd_o),
    .host_wait_o(host_wait_o), .done_o(done_o), .timeout_o(timeout_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one write cycle; d = negedge index after start edge at which nwait rises
  task automatic run_cycle(input bit addr, input logic [7:0] data, input int d,
                           input bit stb_again, input int clr_at);
    int len;
    int exp_len;
    bit to_now;
    exp_len = (d + 3 < TERM) ? d + 3 : TERM;
    to_now  = (d + 3 > TERM);
    @(negedge clk_i);
    wr_addr_i = addr; wr_data_i = data; wr_stb_ni = 1'b0;
    @(negedge clk_i);
    wr_stb_ni = 1'b1;
    chk(host_wait_o == 1'b1, "R2", "busy after start", host_wait_o, 1);
    chk(pd_o == data, "R2", "pd_o", pd_o, data);
    chk(astb_no == !addr, "R2", "astb_no", astb_no, !addr);
    chk(dstb_no == addr, "R2", "dstb_no", dstb_no, addr);
    len = 0;
    for (int n = 0; n < 4 * TERM; n++) begin
      if (!host_wait_o) break;
      len++;
      if (n == d) nwait_i = 1'b1;
      if (stb_again && n == 2) begin wr_stb_ni = 1'b0; wr_data_i = ~data; wr_addr_i = !addr; end
      if (stb_again && n == 3) wr_stb_ni = 1'b1;
      stat_we_i = (n == clr_at); stat_wbit0_i = (n == clr_at);
      @(negedge clk_i);
      if (host_wait_o) chk(pd_o == data, "R9", "pd_o held", pd_o, data);
    end
    stat_we_i = 1'b0; stat_wbit0_i = 1'b0;
    if (to_now) exp_to = 1'b1;
    chk(len == exp_len, (d + 3 == TERM) ? "R5" : (to_now ? "R4" : "R3"),
        "cycle length", len, exp_len);
    chk(timeout_o == exp_to, (d + 3 == TERM) ? "R5" : (clr_at >= 0 ? "R8" : "R4"),
        "timeout flag", timeout_o, exp_to);
    chk(done_o == 1'b1, "R6", "done at end", done_o, 1);
    chk(astb_no && dstb_no, "R6", "strobes released", {astb_no, dstb_no}, 3);
    @(negedge clk_i);
    chk(done_o == 1'b0, "R6", "done one cycle", done_o, 0);
    nwait_i = 1'b0;
    repeat (3) begin
      @(negedge clk_i);
      chk(host_wait_o == 1'b0, stb_again ? "R9" : "R6", "stays idle", host_wait_o, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(host_wait_o == 0 && done_o == 0 && timeout_o == 0, "R1", "status after reset",
        {host_wait_o, done_o, timeout_o}, 0);
    chk(astb_no && dstb_no && pd_o == 0, "R1", "port after reset",
        {astb_no, dstb_no, pd_o}, 16'h300);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // sweep acknowledge delay across the watchdog boundary (R3, R4, R5)
    for (int d = 0; d <= TERM + 1; d++)
      run_cycle(d[0], 8'(d * 37 + 5), d, 1'b0, -1);

    // flag must survive normal cycles (R7)
    run_cycle(1'b1, 8'h5a, 2, 1'b0, -1);
    chk(timeout_o == 1'b1, "R7", "sticky over normal cycle", timeout_o, 1);

    // write with bit0 = 0 leaves flag (R7)
    stat_we_i = 1'b1; stat_wbit0_i = 1'b0;
    @(negedge clk_i);
    stat_we_i = 1'b0;
    @(negedge clk_i);
    chk(timeout_o == 1'b1, "R7", "write 0 ignored", timeout_o, 1);

    // write-one-to-clear (R7)
    stat_we_i = 1'b1; stat_wbit0_i = 1'b1;
    @(negedge clk_i);
    stat_we_i = 1'b0; stat_wbit0_i = 1'b0;
    chk(timeout_o == 1'b0, "R7", "w1c clears", timeout_o, 0);
    exp_to = 1'b0;

    // strobe during cycle ignored, normal and timeout endings (R9)
    run_cycle(1'b0, 8'hc3, 5, 1'b1, -1);
    run_cycle(1'b1, 8'h3c, 1000, 1'b1, -1);

    // clear and timeout on the same edge: set wins (R8)
    run_cycle(1'b0, 8'h81, 1000, 1'b0, TERM - 1);
    stat_we_i = 1'b1; stat_wbit0_i = 1'b1;
    @(negedge clk_i);
    stat_we_i = 1'b0; stat_wbit0_i = 1'b0;
    exp_to = 1'b0;
    run_cycle(1'b1, 8'h18, 1000, 1'b0, TERM - 1);
    chk(timeout_o == 1'b1, "R8", "set beats clear from clear state", timeout_o, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule